// File: doc/BRIEF.md
# SMBus Configuration Register Target

This block is an SMBus target that exposes a small bank of byte-wide configuration registers to a host. The host reaches them with indexed block transfers. A write carries a starting index, a byte count and that many data bytes. A read first sets the index with a write header. It then uses a repeated start and the read address, and the target answers with a byte count followed by register contents. The register index advances by one after every data byte, in both directions.

SCL and SDA are sampled by the system clock through synchronizers, so the block needs no clock of its own on the serial side. SDA is driven only through an active-high pull-low enable. A set of strap inputs is captured once, just after reset. The source-select, rate-select and spread-enable fields come either from that captured copy or from a software copy, under a control bit. The decoded fields are brought out as plain outputs for the clocking logic next to this block: per-output enables, stop modes, spread type, stopped-output drive mode and the two divider values.

Top module: `smb_cfg_target`

## Requirements
- R1: After reset SDA is released, the enable register (index 1) is 0xFF, the stop-mode register (index 2) is 0x00, the count register (index 6) is 0x07, control bits 2..0 of index 0 are 0, and both divider registers (indices 10 and 11) are 0x00.
- R2: Only the address bytes 0xDC (write) and 0xDD (read) are acknowledged. After any other address byte the target leaves SDA released and ignores all bytes until the next start.
- R3: A block write (0xDC, index N, count X, X data bytes) acknowledges every byte and stores data byte k into register N+k.
- R4: Data bytes sent beyond the count of a block write are acknowledged and discarded.
- R5: A block read (0xDC, index N, repeated start, 0xDD) returns the count byte first, then registers N, N+1, ... while the host acknowledges, and releases SDA after the host NACK.
- R6: The count byte returned on a read is the current value of register 6, which the host may write.
- R7: Index 0 holds bit 7 source select, bits 6..4 rate select (high to low), bit 3 spread enable, bit 2 software control, bit 1 stopped-output Hi-Z mode, bit 0 center spread. Bits 7..3 are loaded from the strap inputs after reset. A write to bits 7..3 is taken only if bit 2 was already 1 before that byte. While bit 2 is 0, the outputs and a readback of bits 7..3 show the captured strap values.
- R8: Index 3 is read-only and reads as the live strap inputs in bits 7..3 (same order as index 0), with bits 2..0 zero.
- R9: Index 4 reads as {revision nibble, 0x1}, with a revision nibble of 0 by default. Index 5 reads as 0x08. Writes to both are discarded. Indices 7, 8 and 9 read as 0x00.
- R10: Output enable bit i follows register 1 bit i. Stoppable bit i follows register 2 bit i. The 10-bit N divider is {register 10 bits 7..6, register 11}, and the 6-bit M divider is register 10 bits 5..0.
- R11: An index above 11, whether reached directly or by auto-increment, reads as 0x00 and takes no writes until the next stop.
- R12: SDA is released while idle and after a stop, and the pull-low enable changes only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | SMBus clock line as seen at the pad |
| sda_in | input | 1 | SMBus data line as seen at the pad |
| sda_oe | output | 1 | Pull SDA low when 1 |
| strap_src | input | 1 | Strap: input source select |
| strap_rate | input | 3 | Strap: rate select |
| strap_spread | input | 1 | Strap: spread enable |
| src_sel | output | 1 | Effective source select |
| rate_sel | output | 3 | Effective rate select |
| spread_en | output | 1 | Effective spread enable |
| spread_center | output | 1 | 1 = center spread, 0 = down spread |
| sw_ctrl | output | 1 | Software control of source, rate and spread |
| stop_hiz | output | 1 | Stopped outputs float (1) or are driven (0) |
| out_en | output | NUM_OUT | Per-output enable |
| stoppable | output | NUM_OUT | Per-output stop permission |
| ndiv | output | 10 | N divider value |
| mdiv | output | 6 | M divider value |

## Verification
The assertions assume a bus that the synchronizers can resolve. Each level of SCL must last several system clocks. SDA may change only while SCL is low, except at start and stop. The strap inputs must stay still around the first clock after reset. The bench holds each SCL half period for eight clocks, moves SDA two clocks after SCL falls, and changes the straps only between transactions. Under these conditions the target's own SDA drive never moves while SCL is high.

// File: rtl/smbcfg_pkg.sv
package smbcfg_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_INDEX,
    PH_COUNT,
    PH_WDATA,
    PH_RCOUNT,
    PH_RDATA,
    PH_SKIP
  } phase_e;

  localparam int BYTE_W = 8;

  localparam logic [7:0] IDX_CTRL  = 8'd0;
  localparam logic [7:0] IDX_ENA   = 8'd1;
  localparam logic [7:0] IDX_STOP  = 8'd2;
  localparam logic [7:0] IDX_PINS  = 8'd3;
  localparam logic [7:0] IDX_IDENT = 8'd4;
  localparam logic [7:0] IDX_DEV   = 8'd5;
  localparam logic [7:0] IDX_CNT   = 8'd6;
  localparam logic [7:0] IDX_DIVH  = 8'd10;
  localparam logic [7:0] IDX_DIVL  = 8'd11;
  localparam logic [7:0] IDX_LAST  = 8'd11;

  localparam logic [7:0] RST_ENA   = 8'hFF;
  localparam logic [7:0] RST_STOP  = 8'h00;
  localparam logic [7:0] RST_CNT   = 8'h07;
  localparam logic [3:0] VENDOR_NIB = 4'h1;
  localparam logic [7:0] DEV_CODE  = 8'h08;

endpackage

// File: rtl/smbcfg_sync.sv
module smbcfg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_raw,
  input  logic sda_raw,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  // bit 1 = SCL, bit 0 = SDA; both lines share one chain so their delays match
  logic [STAGES-1:0][1:0] chain_q;
  logic [1:0]             prev_q;
  logic [1:0]             cur;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '1;
      prev_q  <= 2'b11;
    end else begin
      chain_q[0] <= {scl_raw, sda_raw};
      for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
      prev_q <= chain_q[STAGES-1];
    end
  end

  assign cur      = chain_q[STAGES-1];
  assign scl_lvl  = cur[1];
  assign sda_lvl  = cur[0];
  assign scl_rise = cur[1] & ~prev_q[1];
  assign scl_fall = ~cur[1] & prev_q[1];
  assign start_ev = cur[1] & prev_q[1] & prev_q[0] & ~cur[0];
  assign stop_ev  = cur[1] & prev_q[1] & ~prev_q[0] & cur[0];

endmodule

// File: rtl/smbcfg_link.sv
module smbcfg_link
  import smbcfg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h6E,
  parameter logic [7:0] LAST_IDX = 8'd11
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_lvl,
  input  logic       sda_lvl,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_ev,
  input  logic       stop_ev,
  input  logic [7:0] rd_data,
  input  logic [7:0] cnt_val,
  output logic       sda_oe,
  output logic       wr_en,
  output logic [7:0] wr_idx,
  output logic [7:0] wr_data,
  output logic [7:0] rd_idx
);
  localparam logic [7:0] ADDR_WR = {DEV_ADDR, 1'b0};
  localparam logic [7:0] ADDR_RD = {DEV_ADDR, 1'b1};

  phase_e     phase_q, phase_d;
  logic [3:0] bit_q, bit_d;
  logic [7:0] rx_q, rx_d;
  logic [7:0] tx_q, tx_d;
  logic [7:0] idx_q, idx_d;
  logic [7:0] left_q, left_d;
  logic       tx_on_q, tx_on_d;
  logic       mack_q, mack_d;
  logic       oe_q, oe_d;

  function automatic logic [7:0] bump(input logic [7:0] v);
    return (v == 8'hFF) ? v : v + 8'd1;
  endfunction

  always_comb begin
    phase_d = phase_q;
    bit_d   = bit_q;
    rx_d    = rx_q;
    tx_d    = tx_q;
    idx_d   = idx_q;
    left_d  = left_q;
    tx_on_d = tx_on_q;
    mack_d  = mack_q;
    oe_d    = oe_q;
    if (stop_ev) begin
      phase_d = PH_IDLE;
      bit_d   = 4'd0;
      tx_on_d = 1'b0;
      oe_d    = 1'b0;
    end else if (start_ev) begin
      phase_d = PH_ADDR;
      bit_d   = 4'd0;
      tx_on_d = 1'b0;
      oe_d    = 1'b0;
    end else if (phase_q != PH_IDLE) begin
      if (scl_rise) begin
        if (bit_q < 4'd8) begin
          rx_d  = {rx_q[6:0], sda_lvl};
          bit_d = bit_q + 4'd1;
        end else if (bit_q == 4'd8) begin
          mack_d = ~sda_lvl;
          bit_d  = 4'd9;
        end
      end else if (scl_fall) begin
        if (bit_q == 4'd8) begin
          if (tx_on_q) begin
            oe_d = 1'b0;
          end else begin
            case (phase_q)
              PH_ADDR: begin
                if (rx_q == ADDR_WR) begin
                  phase_d = PH_INDEX;
                  oe_d    = 1'b1;
                end else if (rx_q == ADDR_RD) begin
                  phase_d = PH_RCOUNT;
                  oe_d    = 1'b1;
                end else begin
                  phase_d = PH_SKIP;
                end
              end
              PH_INDEX: begin
                idx_d   = rx_q;
                phase_d = PH_COUNT;
                oe_d    = 1'b1;
              end
              PH_COUNT: begin
                left_d  = rx_q;
                phase_d = PH_WDATA;
                oe_d    = 1'b1;
              end
              PH_WDATA: begin
                oe_d = 1'b1;
                if (left_q != 8'd0) begin
                  left_d = left_q - 8'd1;
                  idx_d  = bump(idx_q);
                end
              end
              default: oe_d = 1'b0;
            endcase
          end
        end else if (bit_q == 4'd9) begin
          bit_d = 4'd0;
          if (tx_on_q) begin
            if (mack_q) begin
              tx_d    = rd_data;
              oe_d    = ~rd_data[7];
              idx_d   = bump(idx_q);
              phase_d = PH_RDATA;
            end else begin
              tx_on_d = 1'b0;
              oe_d    = 1'b0;
              phase_d = PH_SKIP;
            end
          end else if (phase_q == PH_RCOUNT) begin
            tx_d    = cnt_val;
            oe_d    = ~cnt_val[7];
            tx_on_d = 1'b1;
          end else begin
            oe_d = 1'b0;
          end
        end else if (tx_on_q && bit_q != 4'd0) begin
          tx_d = {tx_q[6:0], 1'b0};
          oe_d = ~tx_q[6];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      bit_q   <= 4'd0;
      rx_q    <= 8'd0;
      tx_q    <= 8'd0;
      idx_q   <= 8'd0;
      left_q  <= 8'd0;
      tx_on_q <= 1'b0;
      mack_q  <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      phase_q <= phase_d;
      bit_q   <= bit_d;
      rx_q    <= rx_d;
      tx_q    <= tx_d;
      idx_q   <= idx_d;
      left_q  <= left_d;
      tx_on_q <= tx_on_d;
      mack_q  <= mack_d;
      oe_q    <= oe_d;
    end
  end

  assign sda_oe  = oe_q;
  assign rd_idx  = idx_q;
  assign wr_idx  = idx_q;
  assign wr_data = rx_q;
  assign wr_en   = (phase_q == PH_WDATA) && !tx_on_q && scl_fall && (bit_q == 4'd8)
                   && (left_q != 8'd0) && (idx_q <= LAST_IDX);

  // R12: the data line is let go once a stop has been seen
  assert_release_after_stop_R12: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> !sda_oe);

  // R12: the pull-low enable never moves while SCL is high
  assert_drive_scl_low_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(oe_q) |-> !scl_lvl);

  // R2: a foreign address leaves the line alone for the rest of the transfer
  assert_skip_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_SKIP) |-> !oe_q);

  // R5: transmit mode only exists inside the read phases
  assert_tx_in_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_on_q |-> (phase_q == PH_RCOUNT || phase_q == PH_RDATA));

endmodule

// File: rtl/smbcfg_regs.sv
module smbcfg_regs
  import smbcfg_pkg::*;
#(
  parameter int         NUM_OUT = 8,
  parameter logic [3:0] REV_ID  = 4'h0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [4:0]         strap_bits,
  input  logic               wr_en,
  input  logic [7:0]         wr_idx,
  input  logic [7:0]         wr_data,
  input  logic [7:0]         rd_idx,
  output logic [7:0]         rd_data,
  output logic [7:0]         cnt_val,
  output logic               src_sel,
  output logic [2:0]         rate_sel,
  output logic               spread_en,
  output logic               spread_center,
  output logic               sw_ctrl,
  output logic               stop_hiz,
  output logic [NUM_OUT-1:0] out_en,
  output logic [NUM_OUT-1:0] stoppable,
  output logic [9:0]         ndiv,
  output logic [5:0]         mdiv
);
  logic [4:0] lat_q, lat_d;
  logic [4:0] sw_q, sw_d;
  logic [2:0] lo_q, lo_d;
  logic [7:0] ena_q, ena_d;
  logic [7:0] stp_q, stp_d;
  logic [7:0] cnt_q, cnt_d;
  logic [7:0] divh_q, divh_d;
  logic [7:0] divl_q, divl_d;
  logic       done_q, done_d;
  logic [4:0] eff;

  always_comb begin
    lat_d  = lat_q;
    sw_d   = sw_q;
    lo_d   = lo_q;
    ena_d  = ena_q;
    stp_d  = stp_q;
    cnt_d  = cnt_q;
    divh_d = divh_q;
    divl_d = divl_q;
    done_d = done_q;
    if (!done_q) begin
      lat_d  = strap_bits;
      sw_d   = strap_bits;
      done_d = 1'b1;
    end else if (wr_en) begin
      case (wr_idx)
        IDX_CTRL: begin
          lo_d = wr_data[2:0];
          if (lo_q[2]) sw_d = wr_data[7:3];
        end
        IDX_ENA:  ena_d  = wr_data;
        IDX_STOP: stp_d  = wr_data;
        IDX_CNT:  cnt_d  = wr_data;
        IDX_DIVH: divh_d = wr_data;
        IDX_DIVL: divl_d = wr_data;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q  <= 5'd0;
      sw_q   <= 5'd0;
      lo_q   <= 3'd0;
      ena_q  <= RST_ENA;
      stp_q  <= RST_STOP;
      cnt_q  <= RST_CNT;
      divh_q <= 8'd0;
      divl_q <= 8'd0;
      done_q <= 1'b0;
    end else begin
      lat_q  <= lat_d;
      sw_q   <= sw_d;
      lo_q   <= lo_d;
      ena_q  <= ena_d;
      stp_q  <= stp_d;
      cnt_q  <= cnt_d;
      divh_q <= divh_d;
      divl_q <= divl_d;
      done_q <= done_d;
    end
  end

  assign eff = lo_q[2] ? sw_q : lat_q;

  always_comb begin
    case (rd_idx)
      IDX_CTRL:  rd_data = {eff, lo_q};
      IDX_ENA:   rd_data = ena_q;
      IDX_STOP:  rd_data = stp_q;
      IDX_PINS:  rd_data = {strap_bits, 3'b000};
      IDX_IDENT: rd_data = {REV_ID, VENDOR_NIB};
      IDX_DEV:   rd_data = DEV_CODE;
      IDX_CNT:   rd_data = cnt_q;
      IDX_DIVH:  rd_data = divh_q;
      IDX_DIVL:  rd_data = divl_q;
      default:   rd_data = 8'h00;
    endcase
  end

  assign cnt_val       = cnt_q;
  assign src_sel       = eff[4];
  assign rate_sel      = eff[3:1];
  assign spread_en     = eff[0];
  assign sw_ctrl       = lo_q[2];
  assign stop_hiz      = lo_q[1];
  assign spread_center = lo_q[0];
  assign out_en        = ena_q[NUM_OUT-1:0];
  assign stoppable     = stp_q[NUM_OUT-1:0];
  assign ndiv          = {divh_q[7:6], divl_q};
  assign mdiv          = divh_q[5:0];

  // R11: the protocol side never asks for a store past the last register
  assert_wr_in_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_idx <= IDX_LAST));

  // R10: enables move only on a store aimed at their register
  assert_ena_by_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ena_q) |-> $past(wr_en && wr_idx == IDX_ENA));

  // R7: under hardware control the strapped fields hold still
  assert_hw_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && $past(done_q) && !lo_q[2] && !$past(lo_q[2]))
      |-> $stable({src_sel, rate_sel, spread_en}));

endmodule

// File: rtl/smb_cfg_target.sv
module smb_cfg_target
  import smbcfg_pkg::*;
#(
  parameter int         NUM_OUT     = 8,
  parameter int         SYNC_STAGES = 2,
  parameter logic [6:0] DEV_ADDR    = 7'h6E,
  parameter logic [3:0] REV_ID      = 4'h0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_in,
  input  logic               sda_in,
  output logic               sda_oe,
  input  logic               strap_src,
  input  logic [2:0]         strap_rate,
  input  logic               strap_spread,
  output logic               src_sel,
  output logic [2:0]         rate_sel,
  output logic               spread_en,
  output logic               spread_center,
  output logic               sw_ctrl,
  output logic               stop_hiz,
  output logic [NUM_OUT-1:0] out_en,
  output logic [NUM_OUT-1:0] stoppable,
  output logic [9:0]         ndiv,
  output logic [5:0]         mdiv
);
  logic       scl_lvl, sda_lvl, scl_rise, scl_fall, start_ev, stop_ev;
  logic       wr_en;
  logic [7:0] wr_idx, wr_data, rd_idx, rd_data, cnt_val;

  smbcfg_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_raw  (scl_in),
    .sda_raw  (sda_in),
    .scl_lvl  (scl_lvl),
    .sda_lvl  (sda_lvl),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_ev (start_ev),
    .stop_ev  (stop_ev)
  );

  smbcfg_link #(.DEV_ADDR(DEV_ADDR), .LAST_IDX(IDX_LAST)) u_link (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_lvl  (scl_lvl),
    .sda_lvl  (sda_lvl),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_ev (start_ev),
    .stop_ev  (stop_ev),
    .rd_data  (rd_data),
    .cnt_val  (cnt_val),
    .sda_oe   (sda_oe),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_data  (wr_data),
    .rd_idx   (rd_idx)
  );

  smbcfg_regs #(.NUM_OUT(NUM_OUT), .REV_ID(REV_ID)) u_regs (
    .clk           (clk),
    .rst_n         (rst_n),
    .strap_bits    ({strap_src, strap_rate, strap_spread}),
    .wr_en         (wr_en),
    .wr_idx        (wr_idx),
    .wr_data       (wr_data),
    .rd_idx        (rd_idx),
    .rd_data       (rd_data),
    .cnt_val       (cnt_val),
    .src_sel       (src_sel),
    .rate_sel      (rate_sel),
    .spread_en     (spread_en),
    .spread_center (spread_center),
    .sw_ctrl       (sw_ctrl),
    .stop_hiz      (stop_hiz),
    .out_en        (out_en),
    .stoppable     (stoppable),
    .ndiv          (ndiv),
    .mdiv          (mdiv)
  );

endmodule

// File: tb/smb_cfg_target_tb_top.sv
module smb_cfg_target_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HB         = 8;
  localparam int WDOG       = 150000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       scl_m, sda_m;
  logic       sda_line;
  logic       sda_oe;
  logic       strap_src, strap_spread;
  logic [2:0] strap_rate;
  logic       src_sel, spread_en, spread_center, sw_ctrl, stop_hiz;
  logic [2:0] rate_sel;
  logic [7:0] out_en, stoppable;
  logic [9:0] ndiv;
  logic [5:0] mdiv;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;

  logic [7:0] wbuf [4];
  logic [7:0] rbuf [8];
  logic [7:0] rcnt;
  logic       all_ack;

  // {requirement number, index, byte written, byte expected back}
  localparam logic [31:0] VEC [9] = '{
    32'h0A_01_A5_A5,   // R10 enable register
    32'h0A_02_3C_3C,   // R10 stop-mode register
    32'h0A_0A_C7_C7,   // R10 divider high
    32'h0A_0B_5A_5A,   // R10 divider low
    32'h09_05_FF_08,   // R9 device code ignores writes
    32'h09_04_00_01,   // R9 identity nibbles
    32'h09_07_77_00,   // R9 reserved reads zero
    32'h08_03_FF_B0,   // R8 live strap readback
    32'h0B_0C_55_00    // R11 beyond last register
  };

  always #(CLK_PERIOD/2) clk = ~clk;

  assign sda_line = sda_m & ~sda_oe;

  smb_cfg_target dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .scl_in        (scl_m),
    .sda_in        (sda_line),
    .sda_oe        (sda_oe),
    .strap_src     (strap_src),
    .strap_rate    (strap_rate),
    .strap_spread  (strap_spread),
    .src_sel       (src_sel),
    .rate_sel      (rate_sel),
    .spread_en     (spread_en),
    .spread_center (spread_center),
    .sw_ctrl       (sw_ctrl),
    .stop_hiz      (stop_hiz),
    .out_en        (out_en),
    .stoppable     (stoppable),
    .ndiv          (ndiv),
    .mdiv          (mdiv)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == WDOG) begin
      checks = checks + 1;
      errors = errors + 1;
      $display("FAIL R12 watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; scl_m = 1'b1; tick(HB);
    sda_m = 1'b0; tick(HB);
    scl_m = 1'b0; tick(2);
  endtask

  task automatic bus_rstart();
    sda_m = 1'b1; tick(HB);
    scl_m = 1'b1; tick(HB);
    sda_m = 1'b0; tick(HB);
    scl_m = 1'b0; tick(2);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(HB);
    scl_m = 1'b1; tick(HB);
    sda_m = 1'b1; tick(HB);
  endtask

  task automatic put_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(HB);
      scl_m = 1'b1; tick(HB);
      scl_m = 1'b0; tick(2);
    end
    sda_m = 1'b1; tick(HB);
    scl_m = 1'b1; tick(HB);
    ack = ~sda_line;
    scl_m = 1'b0; tick(2);
  endtask

  task automatic get_byte(input logic ack_it, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(HB);
      scl_m = 1'b1; tick(HB);
      b[i] = sda_line;
      scl_m = 1'b0;
    end
    tick(2);
    sda_m = ~ack_it; tick(HB);
    scl_m = 1'b1; tick(HB);
    scl_m = 1'b0; tick(2);
    sda_m = 1'b1;
  endtask

  task automatic wr_block(input logic [7:0] idx, input logic [7:0] cnt, input int nsend);
    logic ak;
    all_ack = 1'b1;
    bus_start();
    put_byte(8'hDC, ak); all_ack &= ak;
    put_byte(idx, ak);   all_ack &= ak;
    put_byte(cnt, ak);   all_ack &= ak;
    for (int k = 0; k < nsend; k++) begin
      put_byte(wbuf[k], ak); all_ack &= ak;
    end
    bus_stop();
  endtask

  task automatic rd_block(input logic [7:0] idx, input int n);
    logic ak;
    all_ack = 1'b1;
    bus_start();
    put_byte(8'hDC, ak); all_ack &= ak;
    put_byte(idx, ak);   all_ack &= ak;
    bus_rstart();
    put_byte(8'hDD, ak); all_ack &= ak;
    get_byte(n != 0, rcnt);
    for (int k = 0; k < n; k++) get_byte(k < n - 1, rbuf[k]);
    bus_stop();
  endtask

  initial begin
    logic ak;
    scl_m = 1'b1; sda_m = 1'b1;
    strap_src = 1'b1; strap_rate = 3'b011; strap_spread = 1'b0;
    rst_n = 1'b0;
    tick(5);
    rst_n = 1'b1;
    tick(10);

    // reset state at the ports (R1, R7 strap capture)
    chk("R1 sda released", {31'd0, sda_oe}, 32'd0);
    chk("R1 enables", {24'd0, out_en}, 32'hFF);
    chk("R1 stop modes", {24'd0, stoppable}, 32'h00);
    chk("R1 dividers", {16'd0, ndiv, mdiv}, 32'd0);
    chk("R1 control low bits", {29'd0, sw_ctrl, stop_hiz, spread_center}, 32'd0);
    chk("R7 strapped fields", {27'd0, src_sel, rate_sel, spread_en}, 32'h16);

    // full default read: count then indices 0..6 (R1, R5, R8, R9)
    rd_block(8'd0, 7);
    chk("R5 read acks", {31'd0, all_ack}, 32'd1);
    chk("R1 count byte", {24'd0, rcnt}, 32'h07);
    chk("R7 ctrl readback", {24'd0, rbuf[0]}, 32'hB0);
    chk("R1 enable readback", {24'd0, rbuf[1]}, 32'hFF);
    chk("R1 stop readback", {24'd0, rbuf[2]}, 32'h00);
    chk("R8 pins readback", {24'd0, rbuf[3]}, 32'hB0);
    chk("R9 identity", {24'd0, rbuf[4]}, 32'h01);
    chk("R9 device code", {24'd0, rbuf[5]}, 32'h08);
    chk("R1 count register", {24'd0, rbuf[6]}, 32'h07);
    chk("R12 idle after read", {31'd0, sda_oe}, 32'd0);

    // R6: shorten the read length to one byte
    wbuf[0] = 8'h01;
    wr_block(8'd6, 8'd1, 1);
    chk("R3 write acks", {31'd0, all_ack}, 32'd1);
    rd_block(8'd0, 1);
    chk("R6 count follows register", {24'd0, rcnt}, 32'h01);

    // vector walk
    for (int v = 0; v < 9; v++) begin
      wbuf[0] = VEC[v][15:8];
      wr_block(VEC[v][23:16], 8'd1, 1);
      rd_block(VEC[v][23:16], 1);
      chk($sformatf("R%0d vec %0d ack", VEC[v][31:24], v), {31'd0, all_ack}, 32'd1);
      chk($sformatf("R%0d vec %0d data", VEC[v][31:24], v), {24'd0, rbuf[0]}, {24'd0, VEC[v][7:0]});
    end
    chk("R10 enables port", {24'd0, out_en}, 32'hA5);
    chk("R10 stoppable port", {24'd0, stoppable}, 32'h3C);
    chk("R10 n divider", {22'd0, ndiv}, 32'h35A);
    chk("R10 m divider", {26'd0, mdiv}, 32'h07);

    // R2: foreign address is not acknowledged and what follows is ignored
    bus_start();
    put_byte(8'hA0, ak);
    chk("R2 foreign address nack", {31'd0, ak}, 32'd0);
    put_byte(8'h01, ak);
    chk("R2 skipped byte nack", {31'd0, ak}, 32'd0);
    put_byte(8'h01, ak);
    put_byte(8'h00, ak);
    bus_stop();
    chk("R2 enables untouched", {24'd0, out_en}, 32'hA5);

    // R3 and R10: two-byte write into the divider pair
    wbuf[0] = 8'h81; wbuf[1] = 8'h23;
    wr_block(8'd10, 8'd2, 2);
    chk("R3 multi write acks", {31'd0, all_ack}, 32'd1);
    chk("R10 m divider after multi", {26'd0, mdiv}, 32'h01);
    chk("R3 n divider after multi", {22'd0, ndiv}, 32'h223);

    // R4: byte beyond the count is acknowledged and dropped
    wbuf[0] = 8'h0F; wbuf[1] = 8'hEE;
    wr_block(8'd1, 8'd1, 2);
    chk("R4 extra byte acked", {31'd0, all_ack}, 32'd1);
    chk("R4 first byte stored", {24'd0, out_en}, 32'h0F);
    chk("R4 next register kept", {24'd0, stoppable}, 32'h3C);

    // R5 with R6: three-byte read from index 0
    wbuf[0] = 8'h03;
    wr_block(8'd6, 8'd1, 1);
    rd_block(8'd0, 3);
    chk("R6 count three", {24'd0, rcnt}, 32'h03);
    chk("R5 byte 0", {24'd0, rbuf[0]}, 32'hB0);
    chk("R5 byte 1", {24'd0, rbuf[1]}, 32'h0F);
    chk("R5 byte 2", {24'd0, rbuf[2]}, 32'h3C);
    chk("R5 released after nack", {31'd0, sda_oe}, 32'd0);

    // R7: upper bits refused while software control was off before the byte
    wbuf[0] = 8'h2D;
    wr_block(8'd0, 8'd1, 1);
    chk("R7 sw bit set", {31'd0, sw_ctrl}, 32'd1);
    chk("R7 center set", {31'd0, spread_center}, 32'd1);
    chk("R7 upper bits refused", {27'd0, src_sel, rate_sel, spread_en}, 32'h16);
    wr_block(8'd0, 8'd1, 1);
    chk("R7 upper bits taken", {27'd0, src_sel, rate_sel, spread_en}, 32'h05);
    wbuf[0] = 8'h02;
    wr_block(8'd0, 8'd1, 1);
    chk("R7 back to straps", {27'd0, src_sel, rate_sel, spread_en}, 32'h16);
    chk("R7 hiz mode", {30'd0, stop_hiz, sw_ctrl}, 32'h2);
    rd_block(8'd0, 1);
    chk("R7 ctrl readback hw mode", {24'd0, rbuf[0]}, 32'hB2);

    // R8: live pins show in index 3, latched outputs stay
    strap_rate = 3'b100;
    tick(4);
    rd_block(8'd3, 1);
    chk("R8 live pins", {24'd0, rbuf[0]}, 32'hC0);
    chk("R8 outputs stay latched", {29'd0, rate_sel}, 32'h3);
    strap_rate = 3'b011;

    // R11: auto-increment past the last register
    wbuf[0] = 8'h99; wbuf[1] = 8'h11; wbuf[2] = 8'h22;
    wr_block(8'd11, 8'd3, 3);
    chk("R11 write acks", {31'd0, all_ack}, 32'd1);
    rd_block(8'd11, 3);
    chk("R11 last register", {24'd0, rbuf[0]}, 32'h99);
    chk("R11 past end 1", {24'd0, rbuf[1]}, 32'h00);
    chk("R11 past end 2", {24'd0, rbuf[2]}, 32'h00);
    chk("R10 n divider final", {22'd0, ndiv}, 32'h299);
    chk("R12 idle at end", {31'd0, sda_oe}, 32'd0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule